// File: doc/BRIEF.md
# Program Address Register Unit

This block keeps the 16-bit address of the next instruction a small processor core will fetch. Each cycle in which the fetch strobe is high, the stored address moves forward by one. The value is also a register in the core's register space, selected by a module number and an index. Software can read it there without side effects. Any write there replaces the address, so a write acts as a jump.

After any reset the address is the fixed vector 8000h, not zero. When a register write and a fetch strobe fall in the same cycle, the written address is taken and the increment for that cycle is dropped. Read data is combinational. It shows the stored value only while a matching read is requested and is zero otherwise.

Top module: `prog_addr_reg`

## Requirements
- R1: While reset (rstN low) is applied, and on the first cycle after it, fetchAddr equals 16'h8000.
- R2: A cycle with fetchStb high and no matching write makes fetchAddr one larger after the next rising clock edge.
- R3: A cycle with neither fetchStb nor a matching write leaves fetchAddr unchanged.
- R4: A write (regWr high) with regMod = 5'h0C and regIdx = 5'h00 loads regWrData into fetchAddr at the next rising clock edge.
- R5: A write whose regMod or regIdx differs from 5'h0C / 5'h00 leaves fetchAddr exactly as it would be without the write.
- R6: When a matching write and fetchStb occur in the same cycle, fetchAddr takes the written value and no increment is applied.
- R7: Incrementing from 16'hFFFF gives 16'h0000.
- R8: regRdData equals fetchAddr in the same cycle when regRd is high with regMod = 5'h0C and regIdx = 5'h00, and is 16'h0000 otherwise.
- R9: A read, matching or not, does not change fetchAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| fetchStb | input | 1 | One instruction fetched this cycle |
| regMod | input | 5 | Register-space module number |
| regIdx | input | 5 | Register-space index within the module |
| regWr | input | 1 | Register write request |
| regWrData | input | 16 | Register write data |
| regRd | input | 1 | Register read request |
| fetchAddr | output | 16 | Address of the next instruction |
| regRdData | output | 16 | Register read data, zero when not selected |

## Verification
fetchAddr is registered: the effect of a fetch strobe, a write or a reset appears one rising edge after the stimulus. The bench therefore drives inputs on the falling edge and compares fetchAddr at the following falling edge against its own arithmetic model. regRdData is combinational, so it is due in the cycle of the request. It is sampled one nanosecond after the inputs settle, before the edge that would update the stored value. This is how the bench shows that a read in the same cycle as a write returns the old address.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;
  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic load;   // take the written address
    logic step;   // advance by one
    logic drive;  // present the value on the read bus
  } pa_strobe_t;
endpackage

// File: rtl/prog_addr_ctrl.sv
module prog_addr_ctrl
  import prog_addr_pkg::*;
#(
  parameter int MOD_W = 5,
  parameter int IDX_W = 5,
  parameter logic [MOD_W-1:0] MY_MOD = 5'h0C,
  parameter logic [IDX_W-1:0] MY_IDX = 5'h00
) (
  input  logic             fetchStb,
  input  logic [MOD_W-1:0] regMod,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             regWr,
  input  logic             regRd,
  output pa_strobe_t       strobes
);
  logic selHit;

  always_comb begin
    selHit        = (regMod == MY_MOD) && (regIdx == MY_IDX);
    strobes.load  = regWr && selHit;
    // A software jump takes precedence over the fetch increment.
    strobes.step  = fetchStb && !strobes.load;
    strobes.drive = regRd && selHit;
  end
endmodule

// File: rtl/prog_addr_dp.sv
module prog_addr_dp
  import prog_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pa_strobe_t        strobes,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    addrNext = addrQ;
    if (strobes.load)      addrNext = wrData;
    else if (strobes.step) addrNext = addrQ + ONE;  // wraps silently
  end

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= RESET_VEC;
    else       addrQ <= addrNext;
  end

  assign curAddr = addrQ;
  assign rdData  = strobes.drive ? addrQ : '0;
endmodule

// File: rtl/prog_addr_reg.sv
module prog_addr_reg
  import prog_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 5,
  parameter int IDX_W  = 5,
  parameter logic [MOD_W-1:0]  MY_MOD    = 5'h0C,
  parameter logic [IDX_W-1:0]  MY_IDX    = 5'h00,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchStb,
  input  logic [MOD_W-1:0]  regMod,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              regRd,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] regRdData
);
  pa_strobe_t strobes;

  prog_addr_ctrl #(
    .MOD_W(MOD_W), .IDX_W(IDX_W), .MY_MOD(MY_MOD), .MY_IDX(MY_IDX)
  ) u_ctrl (
    .fetchStb(fetchStb), .regMod(regMod), .regIdx(regIdx),
    .regWr(regWr), .regRd(regRd), .strobes(strobes)
  );

  prog_addr_dp #(
    .ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .curAddr(fetchAddr), .rdData(regRdData)
  );
endmodule

// File: rtl/prog_addr_chk.sv
module prog_addr_chk #(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 5,
  parameter int IDX_W  = 5,
  parameter logic [MOD_W-1:0]  MY_MOD    = 5'h0C,
  parameter logic [IDX_W-1:0]  MY_IDX    = 5'h00,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h8000
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchStb,
  input logic [MOD_W-1:0]  regMod,
  input logic [IDX_W-1:0]  regIdx,
  input logic              regWr,
  input logic [ADDR_W-1:0] regWrData,
  input logic              regRd,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] regRdData
);
  logic atMe;
  assign atMe = (regMod == MY_MOD) && (regIdx == MY_IDX);

  a_r1_reset_vec: assert property (@(posedge clk)
    !rstN |=> fetchAddr == RESET_VEC);

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    fetchStb && !(regWr && atMe) |=> fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !fetchStb && !(regWr && atMe) |=> $stable(fetchAddr));

  // R4 and R6: a matching write wins, fetch strobe or not.
  a_r4_load: assert property (@(posedge clk) disable iff (!rstN)
    regWr && atMe |=> fetchAddr == $past(regWrData));

  a_r8_rd_value: assert property (@(posedge clk) disable iff (!rstN)
    regRd && atMe |-> regRdData == fetchAddr);

  a_r8_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && atMe) |-> regRdData == '0);
endmodule

bind prog_addr_reg prog_addr_chk #(
  .ADDR_W(ADDR_W), .MOD_W(MOD_W), .IDX_W(IDX_W),
  .MY_MOD(MY_MOD), .MY_IDX(MY_IDX), .RESET_VEC(RESET_VEC)
) u_chk (.*);

// File: tb/prog_addr_reg_bench.sv
module prog_addr_reg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchStb = 1'b0;
  logic [4:0]  regMod = '0;
  logic [4:0]  regIdx = '0;
  logic        regWr = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRd = 1'b0;
  logic [15:0] fetchAddr;
  logic [15:0] regRdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] model;

  always #10 clk = ~clk;  // 50 MHz

  prog_addr_reg u_prog_addr_reg (
    .clk(clk), .rstN(rstN), .fetchStb(fetchStb), .regMod(regMod),
    .regIdx(regIdx), .regWr(regWr), .regWrData(regWrData), .regRd(regRd),
    .fetchAddr(fetchAddr), .regRdData(regRdData)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, check read data, cross the rising
  // edge, then compare fetchAddr with the model at the next falling edge.
  task automatic doCycle(input logic f, input logic w, input logic r,
                         input logic [4:0] m, input logic [4:0] i,
                         input logic [15:0] d, input string tag);
    bit hit;
    hit = (m == 5'h0C) && (i == 5'h00);
    fetchStb = f; regWr = w; regRd = r; regMod = m; regIdx = i; regWrData = d;
    #1;
    if (r) check("R8 read data", regRdData, hit ? model : 16'h0000);
    else   check("R8 idle read bus", regRdData, 16'h0000);
    if (w && hit)  model = d;
    else if (f)    model = model + 16'd1;
    @(negedge clk);
    check(tag, fetchAddr, model);
    fetchStb = 0; regWr = 0; regRd = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", fetchAddr, 16'h8000);
    rstN = 1'b1;
    model = 16'h8000;
    @(negedge clk);
    check("R1 after reset", fetchAddr, 16'h8000);

    for (int k = 0; k < 4; k++) doCycle(0, 0, 0, 5'h0C, 5'h00, 16'h0, "R3 hold");
    for (int k = 0; k < 20; k++) doCycle(1, 0, 0, 5'(k), 5'(k), 16'h0, "R2 step");

    // Sweep every module/index pair with a write; only one pair may land.
    for (int m = 0; m < 32; m++)
      for (int i = 0; i < 32; i++)
        doCycle(0, 1, 0, 5'(m), 5'(i), 16'(m * 1021 + i * 37 + 16'h0400),
                (m == 12 && i == 0) ? "R4 load" : "R5 ignored write");

    // Write and fetch in the same cycle: write wins.
    for (int k = 0; k < 16; k++) begin
      doCycle(1, 1, 0, 5'h0C, 5'h00, 16'(k * 4099 + 7), "R6 write over fetch");
      doCycle(1, 1, 0, 5'h0D, 5'h00, 16'hDEAD, "R5 miss with fetch");
    end

    // Wrap around the top of the address space.
    doCycle(0, 1, 0, 5'h0C, 5'h00, 16'hFFFE, "R4 load");
    doCycle(1, 0, 0, 5'h0C, 5'h00, 16'h0, "R2 step");
    doCycle(1, 0, 0, 5'h0C, 5'h00, 16'h0, "R7 wrap");
    check("R7 wrap value", fetchAddr, 16'h0000);

    // Read sweep: data only for the matching pair, no side effect.
    doCycle(0, 1, 0, 5'h0C, 5'h00, 16'h5A3C, "R4 load");
    for (int m = 0; m < 32; m++)
      for (int i = 0; i < 32; i++)
        doCycle(0, 0, 1, 5'(m), 5'(i), 16'h0, "R9 read no effect");
    doCycle(0, 0, 0, 5'h0C, 5'h00, 16'h0, "R8 not enabled");

    // Read and write together: read returns the old value.
    doCycle(0, 1, 1, 5'h0C, 5'h00, 16'h1234, "R4 load with read");
    doCycle(1, 0, 1, 5'h0C, 5'h00, 16'h0, "R9 read during fetch");

    // Reset again after activity.
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", fetchAddr, 16'h8000);
    rstN = 1'b1;
    model = 16'h8000;
    doCycle(1, 0, 0, 5'h0C, 5'h00, 16'h0, "R2 step after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule